// File: doc/BRIEF.md
# Five-Channel Register-Mapped PWM Controller

This block generates five independent pulse-width-modulated outputs. Software sets them up through a simple byte-addressed register bus with single-cycle writes and registered reads. One shared register holds an enable bit for each channel. Each channel also has a private window of three registers: a control word, a period and a duty threshold.

Each channel divides the input clock by a power of two, chosen by a 3-bit select, to make its tick. A 13-bit counter counts those ticks from zero up to the period minus one. The output is high while the counter is below the threshold. The period, threshold and divider values that a running channel uses are captured only when a period ends, so software can rewrite them at any time without cutting a pulse short. A channel whose enable bit or run bit is clear holds its counter and prescaler at zero and drives its output low.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset all outputs are low and every register reads zero.
- R2: The register at byte address 0x000 holds one enable bit per channel, with bit n belonging to channel n. It reads back the written bits in [4:0], and its bits above the channel count read zero.
- R3: Channel n's registers sit at byte address 0x10 + n*0x40 + local offset. The control word is at local 0x00, with the divider select in bits [2:0] and the run bit at bit 15. The period is at local 0x2C and the threshold at local 0x30; both are 13 bits wide (bits [12:0]). Each reads back what was written, masked to its fields.
- R4: A read of an unmapped address returns zero. Read data appears on the port one clock edge after the read strobe and is zero in any cycle that follows no read.
- R5: While active, a channel's output is high for threshold*2^div clocks and low for (period-threshold)*2^div clocks in every period.
- R6: The tick lasts 2^div input clocks for every div from 0 to 7. While the channel is active, its counter only holds, steps up by one, or returns to zero.
- R7: A threshold of 0 gives a constant low output. A threshold at or above the period gives a constant high output.
- R8: A channel is active only when both its enable bit and its run bit are set. An inactive channel holds its counter at zero, and its output is low from the second clock edge after the write that deactivated it.
- R9: New period, threshold and divider values written while a channel runs take effect from the next period boundary. The period in progress completes with the old values.
- R10: Channels run independently; the settings of one do not alter the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pwm_out | output | 5 | One PWM output per channel |

## Verification
Read data is due in the cycle after the read strobe. The bench's read task therefore samples on the falling edge that follows the latching rising edge. A deactivating write lands on one rising edge and the output drops on the next, so the off checks start one falling edge after the write task returns. Waveform results are measured rather than timed. A monitor counts the high and low clocks between successive rising edges of each output. It compares each finished pulse against expected items queued by the driver. The driver queues items only after two rising edges, or right after the boundary it means to test, so the shortened first period and the phase of the enable never enter a comparison.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int NUM_CH_DEF = 5;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 13;
    localparam int DIV_W      = 3;
    localparam int PRE_W      = (1 << DIV_W) - 1;

    localparam int CH_BASE    = 'h10;
    localparam int WIN_BITS   = 6;
    localparam int RUN_BIT    = 15;

    localparam logic [ADDR_W-1:0]   GLOBAL_EN_ADDR = '0;
    localparam logic [WIN_BITS-1:0] LOC_CTRL   = 6'h00;
    localparam logic [WIN_BITS-1:0] LOC_PERIOD = 6'h2C;
    localparam logic [WIN_BITS-1:0] LOC_THRESH = 6'h30;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PERIOD,
        SEL_THRESH
    } loc_sel_e;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] thresh;
    } ch_cfg_t;

    function automatic loc_sel_e decode_local(logic [WIN_BITS-1:0] off);
        case (off)
            LOC_CTRL:   return SEL_CTRL;
            LOC_PERIOD: return SEL_PERIOD;
            LOC_THRESH: return SEL_THRESH;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Last prescaler value of a tick: 2^d - 1
    function automatic logic [PRE_W-1:0] presc_last(logic [DIV_W-1:0] d);
        logic [PRE_W:0] weight;
        weight = (PRE_W+1)'(1) << d;
        return PRE_W'(weight - 1'b1);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic                            bus_we,
    input  logic                            bus_re,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [NUM_CH-1:0]               en_mask,
    output ch_cfg_t [NUM_CH-1:0]            cfg
);

    localparam int CIDX_W = ADDR_W - WIN_BITS;

    logic [ADDR_W-1:0]   rel_addr;
    logic                in_chan;
    logic                hit_en;
    logic [NUM_CH-1:0]   ch_hit;
    loc_sel_e            sel;
    logic [DATA_W-1:0]   rd_next;

    assign rel_addr = bus_addr - ADDR_W'(CH_BASE);
    assign in_chan  = (bus_addr >= ADDR_W'(CH_BASE));
    assign hit_en   = (bus_addr == GLOBAL_EN_ADDR);
    assign sel      = decode_local(rel_addr[WIN_BITS-1:0]);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
        assign ch_hit[n] = in_chan && (rel_addr[ADDR_W-1:WIN_BITS] == CIDX_W'(n));
    end

    always_comb begin
        rd_next = '0;
        if (hit_en) begin
            rd_next[NUM_CH-1:0] = en_mask;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                case (sel)
                    SEL_CTRL: begin
                        rd_next[RUN_BIT]     = cfg[n].run;
                        rd_next[DIV_W-1:0]   = cfg[n].div;
                    end
                    SEL_PERIOD: rd_next[CNT_W-1:0] = cfg[n].period;
                    SEL_THRESH: rd_next[CNT_W-1:0] = cfg[n].thresh;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask   <= '0;
            cfg       <= '0;
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_re ? rd_next : '0;
            if (bus_we && hit_en) begin
                en_mask <= bus_wdata[NUM_CH-1:0];
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (bus_we && ch_hit[n]) begin
                    case (sel)
                        SEL_CTRL: begin
                            cfg[n].run <= bus_wdata[RUN_BIT];
                            cfg[n].div <= bus_wdata[DIV_W-1:0];
                        end
                        SEL_PERIOD: cfg[n].period <= bus_wdata[CNT_W-1:0];
                        SEL_THRESH: cfg[n].thresh <= bus_wdata[CNT_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  ch_cfg_t          cfg,
    output logic             pwm,
    output logic [CNT_W-1:0] cnt
);

    // Working copy of the settings, refreshed only at a period boundary
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] thresh;
    } shadow_t;

    shadow_t          sh_q,  sh_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic [CNT_W-1:0] cnt_d;
    logic             tick;
    logic             wrap;
    logic [CNT_W:0]   cnt_inc;

    assign tick    = (pre_q == presc_last(sh_q.div));
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign wrap    = (cnt_inc >= {1'b0, sh_q.period});

    always_comb begin
        sh_d  = sh_q;
        pre_d = pre_q;
        cnt_d = cnt;
        if (!active) begin
            pre_d = '0;
            cnt_d = '0;
            sh_d  = '{div: cfg.div, period: cfg.period, thresh: cfg.thresh};
        end else if (tick) begin
            pre_d = '0;
            if (wrap) begin
                cnt_d = '0;
                sh_d  = '{div: cfg.div, period: cfg.period, thresh: cfg.thresh};
            end else begin
                cnt_d = cnt_inc[CNT_W-1:0];
            end
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            pre_q <= '0;
            cnt   <= '0;
            pwm   <= 1'b0;
        end else begin
            sh_q  <= sh_d;
            pre_q <= pre_d;
            cnt   <= cnt_d;
            pwm   <= active && (cnt_d < sh_d.thresh);
        end
    end

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]             en_mask;
    ch_cfg_t [NUM_CH-1:0]          cfg;
    logic [NUM_CH-1:0]             ch_act;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;

    pwm_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .en_mask   (en_mask),
        .cfg       (cfg)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ch_act[n] = en_mask[n] && cfg[n].run;

        pwm_chan chan_i (
            .clk    (clk),
            .rst    (rst),
            .active (ch_act[n]),
            .cfg    (cfg[n]),
            .pwm    (pwm_out[n]),
            .cnt    (ch_cnt[n])
        );
    end

endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input logic                            clk,
    input logic                            rst,
    input logic [11:0]                     bus_addr,
    input logic                            bus_re,
    input logic [31:0]                     bus_rdata,
    input logic [NUM_CH-1:0]               pwm_out,
    input logic [NUM_CH-1:0]               ch_act,
    input logic [NUM_CH-1:0][CNT_W-1:0]    ch_cnt
);

    // R1: outputs low the edge after a reset cycle
    a_r1_reset_low: assert property (@(posedge clk) rst |=> (pwm_out == '0));

    // R4: no read strobe, no read data
    a_r4_rd_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0));

    // R2: enable register upper bits read zero
    a_r2_en_upper: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == '0) |=> (bus_rdata[31:NUM_CH] == '0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        // R8: inactive in the previous cycle means a low output now
        a_r8_off_low: assert property (@(posedge clk) disable iff (rst)
            !$past(ch_act[n]) |-> !pwm_out[n]);

        // R8: an inactive channel holds its counter at zero
        a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
            !ch_act[n] |=> (ch_cnt[n] == '0));

        // R6: the counter only holds, steps by one or restarts
        a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
            ch_act[n] |=> (ch_cnt[n] == '0 || $stable(ch_cnt[n]) ||
                           ch_cnt[n] == CNT_W'($past(ch_cnt[n]) + 1'b1)));
    end

endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_act    (ch_act),
    .ch_cnt    (ch_cnt)
);

// File: tb/pwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_ctrl_tb_top;

    localparam int NCH = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    always #2 clk = ~clk;

    pwm_ctrl #(.NUM_CH(NCH)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [NCH-1:0] en_sw = '0;
    logic done = 1'b0;

    typedef struct {
        int    ch;
        int    hi;
        int    lo;
        string tag;
    } item_t;
    item_t sb[$];

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [11:0] ch_addr(int ch, int loc);
        return 12'(16 + ch * 64 + loc);
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_en(logic [NCH-1:0] m);
        en_sw = m;
        wr(12'h000, 32'(m));
    endtask

    task automatic config_ch(int ch, int div, int per, int thr, bit run);
        wr(ch_addr(ch, 'h00), (run ? 32'h8000 : 32'h0) | 32'(div));
        wr(ch_addr(ch, 'h2C), 32'(per));
        wr(ch_addr(ch, 'h30), 32'(thr));
    endtask

    task automatic push_exp(int ch, int div, int per, int thr, int n, string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.ch = ch; it.hi = thr << div; it.lo = (per - thr) << div; it.tag = tag;
            sb.push_back(it);
        end
    endtask

    // Monitor: measures rise-to-rise pulses and compares them with queued items
    logic [NCH-1:0] prev_o = '0;
    logic [NCH-1:0] armed = '0;
    int hcnt[NCH];
    int lcnt[NCH];
    int rise_cnt[NCH];

    initial begin
        for (int c = 0; c < NCH; c++) begin
            hcnt[c] = 0; lcnt[c] = 0; rise_cnt[c] = 0;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_o = '0;
            armed  = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (pwm_out[c] && !prev_o[c]) begin
                    if (armed[c]) begin
                        int idx;
                        idx = -1;
                        for (int k = 0; k < sb.size(); k++) begin
                            if (idx < 0 && sb[k].ch == c) idx = k;
                        end
                        if (idx >= 0) begin
                            check({sb[idx].tag, " high clocks"}, hcnt[c], sb[idx].hi);
                            check({sb[idx].tag, " low clocks"}, lcnt[c], sb[idx].lo);
                            sb.delete(idx);
                        end
                    end
                    armed[c] = 1'b1;
                    hcnt[c] = 0;
                    lcnt[c] = 0;
                    rise_cnt[c]++;
                end
                if (armed[c]) begin
                    if (pwm_out[c]) hcnt[c]++;
                    else lcnt[c]++;
                end
                prev_o[c] = pwm_out[c];
            end
        end
    end

    task automatic wait_rises(int ch, int k);
        int start;
        start = rise_cnt[ch];
        while (rise_cnt[ch] < start + k) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic hold_level(int ch, bit lvl, int cycles, string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch] != lvl) bad++;
        end
        check({tag, " off-level samples"}, bad, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs after reset", pwm_out, 0);
        rd(12'h000, d);            check("R1 enable reg after reset", d, 0);
        rd(ch_addr(2, 'h2C), d);   check("R1 period reg after reset", d, 0);
        rd(ch_addr(4, 'h00), d);   check("R1 ctrl reg after reset", d, 0);

        // R2: enable register readback and upper bits
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d);            check("R2 enable readback", d, 32'h1F);
        wr(12'h000, 32'h0000_000A);
        rd(12'h000, d);            check("R2 enable partial", d, 32'h0A);
        check("R2 R8 outputs with run bits clear", pwm_out, 0);
        set_en('0);

        // R3: channel windows and field masks
        wr(ch_addr(3, 'h00), 32'hFFFF_FFFF);
        rd(ch_addr(3, 'h00), d);   check("R3 ctrl field mask", d, 32'h8007);
        wr(ch_addr(1, 'h2C), 32'h0000_FFFF);
        rd(ch_addr(1, 'h2C), d);   check("R3 period 13 bits", d, 32'h1FFF);
        wr(ch_addr(4, 'h30), 32'h0000_1234);
        rd(ch_addr(4, 'h30), d);   check("R3 threshold readback", d, 32'h1234);
        rd(ch_addr(0, 'h30), d);   check("R3 window isolation", d, 0);

        // R4: unmapped reads
        rd(12'h004, d);            check("R4 unmapped 0x004", d, 0);
        rd(ch_addr(0, 'h04), d);   check("R4 unmapped local 0x04", d, 0);
        rd(12'h150, d);            check("R4 beyond last channel", d, 0);
        rd(ch_addr(2, 'h3C), d);   check("R4 unmapped local 0x3C", d, 0);

        // R5: basic waveform, div 0
        config_ch(0, 0, 10, 3, 1);
        set_en(5'b00001);
        wait_rises(0, 2);
        push_exp(0, 0, 10, 3, 3, "R5 div0 per10 thr3");
        drain();

        // R6: prescaler divisions
        set_en('0);
        config_ch(0, 2, 6, 2, 1);
        set_en(5'b00001);
        wait_rises(0, 2);
        push_exp(0, 2, 6, 2, 2, "R6 div2 per6 thr2");
        drain();
        set_en('0);
        config_ch(0, 7, 3, 1, 1);
        set_en(5'b00001);
        wait_rises(0, 2);
        push_exp(0, 7, 3, 1, 2, "R6 div7 per3 thr1");
        drain();

        // R10: two more channels alongside channel 0
        set_en('0);
        config_ch(0, 0, 7, 2, 1);
        config_ch(1, 1, 8, 5, 1);
        config_ch(4, 0, 5, 4, 1);
        set_en(5'b10011);
        wait_rises(1, 2);
        wait_rises(4, 2);
        wait_rises(0, 2);
        push_exp(0, 0, 7, 2, 3, "R10 ch0");
        push_exp(1, 1, 8, 5, 3, "R10 ch1");
        push_exp(4, 0, 5, 4, 3, "R10 ch4");
        drain();

        // R9: new values apply at the next boundary
        wait_rises(1, 1);
        push_exp(1, 1, 8, 5, 1, "R9 old period completes");
        wr(ch_addr(1, 'h2C), 32'd4);
        wr(ch_addr(1, 'h30), 32'd1);
        push_exp(1, 1, 4, 1, 2, "R9 new values");
        drain();

        // R7: threshold zero and threshold above the period
        config_ch(2, 0, 5, 0, 1);
        set_en(en_sw | 5'b00100);
        hold_level(2, 1'b0, 20, "R7 thr0 constant low");
        set_en(en_sw & ~5'b00100);
        config_ch(2, 0, 5, 7, 1);
        set_en(en_sw | 5'b00100);
        repeat (3) @(negedge clk);
        hold_level(2, 1'b1, 30, "R7 thr>=period constant high");

        // R8: clearing enable and clearing run bit
        set_en(en_sw & ~5'b10000);
        @(negedge clk);
        hold_level(4, 1'b0, 20, "R8 enable cleared");
        wr(ch_addr(1, 'h00), 32'h0000_0001);
        @(negedge clk);
        hold_level(1, 1'b0, 20, "R8 run bit cleared");
        // R8: reactivated channel restarts from zero with clean periods
        set_en(en_sw | 5'b10000);
        wait_rises(4, 2);
        push_exp(4, 0, 5, 4, 2, "R8 restart");
        drain();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule